// File: doc/BRIEF.md
# Video Capture Window Gate

This block sits right after a video source. On every pixel clock it takes one pixel, HSYNC and VSYNC. It marks which pixels fall inside a programmable rectangle of the incoming frame. The horizontal position is counted in pixel clocks from the selected active edge of HSYNC. The vertical position is counted in lines from the selected active edge of VSYNC. Each axis has its own polarity select, which chooses whether the rising or the falling edge of its sync is active.

The block drives four outputs, one clock after the pixel arrives:
- the pixel data, forced to zero outside the window;
- a valid flag;
- a marker for the first pixel of the window;
- a marker for the last pixel of the window.

The window bounds and the HSYNC polarity are captured at every active VSYNC edge, so a frame is always gated by one fixed window.

The control is a two-state machine:
- `S_SEEK` is the state after reset, before any active VSYNC edge has been seen. No pixel is valid in it.
- `S_FRAME` is entered on the first active VSYNC edge (transition `seek_to_frame`). It stays in place on later edges (transition `frame_restart`), each of which restarts the line count and recaptures the configuration.

Top module: `vwg_window_gate`

## Requirements
- R1: After reset all outputs are 0. No pixel is marked valid until the first active VSYNC edge has been seen.
- R2: The horizontal count restarts at 0 on the pixel clock where the active HSYNC edge is seen. The active edge is rising when the HSYNC polarity select is 0 and falling when it is 1. The count rises by one on each later clock.
- R3: The line count restarts at 0 on the active VSYNC edge. The active edge is rising when the VSYNC polarity select is 0 and falling when it is 1. The line count rises by one on each active HSYNC edge, and a VSYNC edge wins when both edges fall on the same clock.
- R4: A pixel is valid exactly when hstart ≤ hcount ≤ hend and vstart ≤ line ≤ vend. The outputs appear one clock after the pixel is sampled, and the data output is zero for pixels that are not valid.
- R5: The first marker is 1 only for the valid pixel at hcount = hstart on line vstart. The last marker is 1 only for the valid pixel at hcount = hend on line vend.
- R6: If start > end on either axis, no pixel is marked valid.
- R7: Both counts saturate at 1023 and do not wrap. A line longer than 1024 clocks therefore never re-enters a window whose hend is below 1023.
- R8: The offsets and the HSYNC polarity are used as they stood at the most recent active VSYNC edge. Changes made mid-frame take effect only at the next active VSYNC edge. The VSYNC polarity select acts immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| pix_data_i | input | DATA_W | Incoming pixel |
| cfg_hpol_i | input | 1 | HSYNC active edge: 0 rising, 1 falling |
| cfg_vpol_i | input | 1 | VSYNC active edge: 0 rising, 1 falling |
| cfg_hstart_i | input | 10 | First sampled pixel offset |
| cfg_hend_i | input | 10 | Last sampled pixel offset |
| cfg_vstart_i | input | 10 | First sampled line offset |
| cfg_vend_i | input | 10 | Last sampled line offset |
| pix_data_o | output | DATA_W | Gated pixel, zero outside the window |
| pix_valid_o | output | 1 | Pixel inside the window |
| pix_first_o | output | 1 | First pixel of the window |
| pix_last_o | output | 1 | Last pixel of the window |

## Verification
The bench builds the block with its default 16-bit pixel data and the 10-bit position width. At that width a single 2100-clock line drives the horizontal count past saturation: a wrapping counter would re-enter a window placed near 1000, so the saturation case is checked directly. Short 12-clock lines keep the windowed frames small. Both polarity pairs, an inverted window and a mid-frame configuration change are each exercised.

// File: rtl/vwg_pkg.sv
package vwg_pkg;
    parameter int POS_W = 10;
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef enum logic [0:0] {
        S_SEEK  = 1'b0,
        S_FRAME = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic             hpol;
        logic [POS_W-1:0] hstart;
        logic [POS_W-1:0] hend;
        logic [POS_W-1:0] vstart;
        logic [POS_W-1:0] vend;
    } win_cfg_t;
endpackage

// File: rtl/vwg_edge_det.sv
module vwg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic pol_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    // pol 0: low-to-high is active, pol 1: high-to-low is active
    always_comb begin
        edge_o = pol_i ? (prev_q & ~sig_i) : (~prev_q & sig_i);
    end
endmodule

// File: rtl/vwg_pos_counter.sv
module vwg_pos_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         advance_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // value that belongs to the pixel presented in this cycle
    always_comb begin
        if (restart_i)                     cur_o = '0;
        else if (advance_i && cnt_q != MAX) cur_o = cnt_q + 1'b1;
        else                               cur_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= MAX;
        else        cnt_q <= cur_o;
    end

    assign q_o = cnt_q;
endmodule

// File: rtl/vwg_cfg_shadow.sv
module vwg_cfg_shadow
    import vwg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_i,
    input  win_cfg_t cfg_i,
    output win_cfg_t cur_o,
    output win_cfg_t shadow_o
);
    win_cfg_t shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q.hpol   <= 1'b0;
            shadow_q.hstart <= POS_W'(1);
            shadow_q.hend   <= POS_MAX;
            shadow_q.vstart <= POS_W'(1);
            shadow_q.vend   <= POS_MAX;
        end else if (capture_i) begin
            shadow_q <= cfg_i;
        end
    end

    // the capturing pixel already uses the fresh settings
    always_comb begin
        cur_o = capture_i ? cfg_i : shadow_q;
    end

    assign shadow_o = shadow_q;
endmodule

// File: rtl/vwg_window_gate.sv
module vwg_window_gate
    import vwg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [DATA_W-1:0] pix_data_i,
    input  logic              cfg_hpol_i,
    input  logic              cfg_vpol_i,
    input  logic [POS_W-1:0]  cfg_hstart_i,
    input  logic [POS_W-1:0]  cfg_hend_i,
    input  logic [POS_W-1:0]  cfg_vstart_i,
    input  logic [POS_W-1:0]  cfg_vend_i,
    output logic [DATA_W-1:0] pix_data_o,
    output logic              pix_valid_o,
    output logic              pix_first_o,
    output logic              pix_last_o
);
    frame_state_e state_q, state_d;
    win_cfg_t     cfg_in, win_cur, win_shadow;
    logic         v_edge, h_edge;
    logic [POS_W-1:0] hcnt_cur, hcnt_q, vcnt_cur, vcnt_q;
    logic         in_frame, h_in, v_in, hit, hit_first, hit_last;

    always_comb begin
        cfg_in.hpol   = cfg_hpol_i;
        cfg_in.hstart = cfg_hstart_i;
        cfg_in.hend   = cfg_hend_i;
        cfg_in.vstart = cfg_vstart_i;
        cfg_in.vend   = cfg_vend_i;
    end

    vwg_edge_det u_vedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (vsync_i),
        .pol_i  (cfg_vpol_i),
        .edge_o (v_edge)
    );

    vwg_cfg_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (v_edge),
        .cfg_i     (cfg_in),
        .cur_o     (win_cur),
        .shadow_o  (win_shadow)
    );

    vwg_edge_det u_hedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (hsync_i),
        .pol_i  (win_cur.hpol),
        .edge_o (h_edge)
    );

    vwg_pos_counter #(.W(POS_W)) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (h_edge),
        .advance_i (1'b1),
        .cur_o     (hcnt_cur),
        .q_o       (hcnt_q)
    );

    vwg_pos_counter #(.W(POS_W)) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (v_edge),
        .advance_i (h_edge),
        .cur_o     (vcnt_cur),
        .q_o       (vcnt_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_SEEK;
        else        state_q <= state_d;
    end

    // transitions: seek_to_frame on first active VSYNC edge, frame_restart afterwards
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SEEK:  if (v_edge) state_d = S_FRAME;
            S_FRAME: state_d = S_FRAME;
            default: state_d = S_SEEK;
        endcase
    end

    always_comb begin
        in_frame  = (state_q == S_FRAME) || v_edge;
        h_in      = (win_cur.hstart <= hcnt_cur) && (hcnt_cur <= win_cur.hend);
        v_in      = (win_cur.vstart <= vcnt_cur) && (vcnt_cur <= win_cur.vend);
        hit       = in_frame && h_in && v_in;
        hit_first = hit && (hcnt_cur == win_cur.hstart) && (vcnt_cur == win_cur.vstart);
        hit_last  = hit && (hcnt_cur == win_cur.hend) && (vcnt_cur == win_cur.vend);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_data_o  <= '0;
            pix_valid_o <= 1'b0;
            pix_first_o <= 1'b0;
            pix_last_o  <= 1'b0;
        end else begin
            pix_data_o  <= hit ? pix_data_i : '0;
            pix_valid_o <= hit;
            pix_first_o <= hit_first;
            pix_last_o  <= hit_last;
        end
    end
endmodule

// File: rtl/vwg_checker.sv
module vwg_checker
    import vwg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input frame_state_e      state_q,
    input logic              v_edge,
    input logic              h_edge,
    input logic [POS_W-1:0]  hcnt_q,
    input win_cfg_t          win_cur,
    input win_cfg_t          win_shadow,
    input logic [DATA_W-1:0] pix_data_o,
    input logic              pix_valid_o,
    input logic              pix_first_o,
    input logic              pix_last_o
);
    p_quiet_seek_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEEK && !v_edge) |=> !pix_valid_o);

    p_hrestart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        h_edge |=> (hcnt_q == '0));

    p_gated_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> (pix_data_o == '0));

    p_first_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_first_o |-> pix_valid_o);

    p_last_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last_o |-> pix_valid_o);

    p_empty_haxis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cur.hstart > win_cur.hend) |=> !pix_valid_o);

    p_empty_vaxis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cur.vstart > win_cur.vend) |=> !pix_valid_o);

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt_q == POS_MAX && !h_edge) |=> (hcnt_q == POS_MAX));

    p_frozen_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_edge |=> $stable(win_shadow));
endmodule

bind vwg_window_gate vwg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .v_edge      (v_edge),
    .h_edge      (h_edge),
    .hcnt_q      (hcnt_q),
    .win_cur     (win_cur),
    .win_shadow  (win_shadow),
    .pix_data_o  (pix_data_o),
    .pix_valid_o (pix_valid_o),
    .pix_first_o (pix_first_o),
    .pix_last_o  (pix_last_o)
);

// File: tb/vwg_window_gate_tb.sv
module vwg_window_gate_tb;
    localparam int DATA_W = 16;
    localparam int PW = 10;
    localparam int EW = DATA_W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic hpol = 1'b0, vpol = 1'b0;
    logic [PW-1:0] hstart = 10'd1, hend = 10'd1023, vstart = 10'd1, vend = 10'd1023;
    logic [DATA_W-1:0] dout;
    logic valid, first, last;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    // bench reference state
    logic m_hprev = 1'b0, m_vprev = 1'b0, m_frame = 1'b0, m_hpol = 1'b0;
    int   m_hc = 1023, m_vc = 1023;
    int   m_hs = 1, m_he = 1023, m_vs = 1, m_ve = 1023;
    logic [DATA_W-1:0] dcnt = 16'h0100;

    always #4 clk = ~clk;

    vwg_window_gate #(.DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsync_i      (hsync),
        .vsync_i      (vsync),
        .pix_data_i   (din),
        .cfg_hpol_i   (hpol),
        .cfg_vpol_i   (vpol),
        .cfg_hstart_i (hstart),
        .cfg_hend_i   (hend),
        .cfg_vstart_i (vstart),
        .cfg_vend_i   (vend),
        .pix_data_o   (dout),
        .pix_valid_o  (valid),
        .pix_first_o  (first),
        .pix_last_o   (last)
    );

    task automatic step(input logic hs, input logic vs, input string tag);
        logic ve, he, pol, ok, f, l;
        @(negedge clk);
        hsync = hs; vsync = vs; din = dcnt;
        ve  = vpol ? (m_vprev & ~vs) : (~m_vprev & vs);
        if (ve) begin
            m_hpol = hpol; m_hs = hstart; m_he = hend; m_vs = vstart; m_ve = vend;
        end
        pol = m_hpol;
        he  = pol ? (m_hprev & ~hs) : (~m_hprev & hs);
        if (he) m_hc = 0; else if (m_hc < 1023) m_hc = m_hc + 1;
        if (ve) m_vc = 0; else if (he && m_vc < 1023) m_vc = m_vc + 1;
        ok = (m_frame || ve) && m_hs <= m_hc && m_hc <= m_he && m_vs <= m_vc && m_vc <= m_ve;
        f  = ok && m_hc == m_hs && m_vc == m_vs;
        l  = ok && m_hc == m_he && m_vc == m_ve;
        m_frame = m_frame | ve;
        exp_q.push_back({ok, f, l, ok ? dcnt : {DATA_W{1'b0}}});
        tag_q.push_back(tag);
        m_hprev = hs; m_vprev = vs;
        dcnt = dcnt + 1'b1;
        @(posedge clk);
        #1;
    endtask

    // one line: sync active for the first hs_w clocks
    task automatic run_line(input int len, input int hs_w, input logic hact,
                            input logic vs, input string tag);
        for (int i = 0; i < len; i++)
            step((i < hs_w) ? hact : ~hact, vs, tag);
    endtask

    task automatic run_frame(input int lines, input int len, input logic hact,
                             input logic vact, input string tag);
        for (int ln = 0; ln < lines; ln++)
            run_line(len, 2, hact, (ln == 0) ? vact : ~vact, tag);
    endtask

    // scoreboard monitor
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [EW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({valid, first, last, dout} !== e) begin
                n_bad++;
                $display("FAIL %s: got v=%b f=%b l=%b d=%h expected v=%b f=%b l=%b d=%h",
                         t, valid, first, last, dout,
                         e[EW-1], e[EW-2], e[EW-3], e[DATA_W-1:0]);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        n_vec++;
        if ({valid, first, last, dout} !== '0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 0", {valid, first, last, dout});
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: hsync activity without VSYNC edge gives nothing
        hstart = 10'd0; hend = 10'd20; vstart = 10'd0; vend = 10'd5;
        for (int k = 0; k < 3; k++) run_line(12, 2, 1'b1, 1'b0, "R1 seek");

        // R2 R3 R4 R5 positive edges
        hstart = 10'd3; hend = 10'd6; vstart = 10'd1; vend = 10'd2;
        run_frame(4, 12, 1'b1, 1'b1, "R2 R3 R4 R5 pos");
        run_frame(3, 12, 1'b1, 1'b1, "R3 R4 refr");

        // R2 R3 negative edges: park syncs high first (inactive after switch)
        vpol = 1'b1; hpol = 1'b1;
        run_line(6, 0, 1'b1, 1'b0, "R3 idle");
        run_line(6, 6, 1'b1, 1'b1, "R3 park");
        hstart = 10'd0; hend = 10'd4; vstart = 10'd0; vend = 10'd1;
        run_frame(3, 10, 1'b0, 1'b0, "R2 R3 R5 neg");
        vpol = 1'b0; hpol = 1'b0;
        run_line(6, 0, 1'b0, 1'b0, "R3 unpark");

        // R6 inverted windows
        hstart = 10'd8; hend = 10'd2; vstart = 10'd0; vend = 10'd3;
        run_frame(3, 12, 1'b1, 1'b1, "R6 h");
        hstart = 10'd1; hend = 10'd5; vstart = 10'd3; vend = 10'd1;
        run_frame(4, 12, 1'b1, 1'b1, "R6 v");

        // R8 mid-frame change ignored until next VSYNC edge
        hstart = 10'd2; hend = 10'd4; vstart = 10'd0; vend = 10'd3;
        run_line(12, 2, 1'b1, 1'b1, "R8 a");
        hstart = 10'd6; hend = 10'd9; vstart = 10'd2; vend = 10'd2;
        run_line(12, 2, 1'b1, 1'b0, "R8 b");
        run_line(12, 2, 1'b1, 1'b0, "R8 c");
        run_frame(3, 12, 1'b1, 1'b1, "R8 next");

        // R7 saturation on a long line
        hstart = 10'd1000; hend = 10'd1022; vstart = 10'd0; vend = 10'd0;
        run_line(2100, 2, 1'b1, 1'b1, "R7 sat");
        run_line(12, 2, 1'b1, 1'b0, "R7 after");

        repeat (4) @(posedge clk);
        #3;
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R4: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule